// File: doc/BRIEF.md
# MSI Message Engine with Per-Vector Masking

This block sits between a device's interrupt sources and its upstream write path. Each cycle it takes one request bit per vector from device logic. It turns each accepted request into a message-signalled interrupt: an address/data pair presented on a valid/ready port. Configuration comes from the capability register file as plain level inputs: enable, log2 of the granted vector count, message address, message data base and per-vector mask. The block returns the current pending bits so the register file can expose them.

A request for a masked vector is not sent. It is held as a pending bit instead. Held vectors are delivered once they become unmasked, or when MSI is switched on. On that switch-on, pending vectors outside the granted count are thrown away. Unmasked requests wait in a scoreboard with one bit per vector. The output register drains the scoreboard one message at a time, lowest vector first. While MSI is on, the legacy wire interrupt output is held low.

Top module: `msi_engine`

## Requirements
- R1: With a granted count N = 2^k and k > 0, the message data is the 16-bit data base with its low k bits replaced by the vector number. With k = 0 the data base passes unchanged. Bits 31:16 of the 32-bit data word are always zero.
- R2: The message address is the configured address with bits 1:0 forced to zero. It is 64 bits wide when ADDR64 = 1 and 32 bits wide when ADDR64 = 0.
- R3: While enabled, a request for an in-range vector whose mask bit is 1 sets that vector's pending bit and produces no message.
- R4: When the mask bit of a pending vector goes to 0 while enabled, its pending bit is cleared and one message is issued for that vector.
- R5: On the cycle the enable input goes from 0 to 1, pending bits at vector index N and above are discarded.
- R6: On that same enable transition, every pending in-range unmasked vector is delivered in ascending vector order and its pending bit cleared. Masked pending vectors stay pending.
- R7: The wire interrupt output follows its request input while disabled and is 0 while enabled.
- R8: With MASK_EN = 0 the mask input has no effect, every request is delivered and the pending output is always zero.
- R9: Requests that arrive while disabled are dropped without setting pending bits. Requests for vectors at index N and above are dropped as well.
- R10: At most one message is outstanding. While valid is high and ready is low, the valid, address, data and vector outputs hold stable.
- R11: Queued requests are served lowest vector number first, back to back when ready stays high.
- R12: A requested k above log2(MAX_VEC) is treated as log2(MAX_VEC).
- R13: With the output free, a request sampled at clock edge t makes valid high after edge t+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_req_i | input | MAX_VEC | Per-vector request, one bit per vector |
| cfg_enable_i | input | 1 | MSI enable |
| cfg_log_vec_i | input | 3 | Log2 of the granted vector count |
| cfg_addr_i | input | 64 or 32 | Message address (ADDR64 selects) |
| cfg_data_i | input | 16 | Message data base |
| cfg_mask_i | input | MAX_VEC | Per-vector mask, 1 = masked |
| pend_o | output | MAX_VEC | Pending bits returned to the register file |
| intx_req_i | input | 1 | Legacy wire interrupt request from device logic |
| intx_o | output | 1 | Legacy wire interrupt toward the pin |
| msg_valid_o | output | 1 | Message valid |
| msg_ready_i | input | 1 | Message accepted by the write path |
| msg_addr_o | output | 64 or 32 | Message address |
| msg_data_o | output | 32 | Message data |
| msg_vec_o | output | log2(MAX_VEC) | Vector number of the message |

## Verification
The bench builds the engine with MAX_VEC = 8, 64-bit addressing and masking on. With that size, every vector under every granted count from 1 to 8 can be sent in turn, and the data merge can be checked against two data bases. The small size also makes the clamp of an oversized count to 8 easy to reach. A second instance with MASK_EN = 0 and 32-bit addressing shares the stimulus and covers the variant with no masking and the narrow address path. Multi-vector request patterns exercise ascending service, the discard on enable, and output holding under backpressure.

// File: rtl/msi_pkg.sv
package msi_pkg;
  localparam int unsigned LOGW = 3;   // width of the vector-count field
  localparam int unsigned DATAW = 32;
  localparam int unsigned BASEW = 16;
endpackage

// File: rtl/msi_pick.sv
module msi_pick #(
  parameter int unsigned N  = 32,
  localparam int unsigned VW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  output logic [N-1:0]  gnt_o,
  output logic [VW-1:0] idx_o,
  output logic          any_o
);
  logic [N:0] seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < N; i++) begin : g_chain
    assign gnt_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1] = seen[i] | req_i[i];
  end
  assign any_o = seen[N];

  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = VW'(i);
    end
  end
endmodule

// File: rtl/msi_msg_fmt.sv
module msi_msg_fmt
  import msi_pkg::*;
#(
  parameter int unsigned N      = 32,
  parameter int unsigned ADDR_W = 64,
  localparam int unsigned VW    = $clog2(N)
) (
  input  logic [BASEW-1:0]  base_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LOGW-1:0]   lg_i,
  input  logic [VW-1:0]     vec_i,
  output logic [DATAW-1:0]  data_o,
  output logic [ADDR_W-1:0] addr_o
);
  logic [BASEW-1:0] low;

  assign low    = (BASEW'(1) << lg_i) - BASEW'(1);
  assign data_o = {{(DATAW-BASEW){1'b0}}, (base_i & ~low) | (BASEW'(vec_i) & low)};
  assign addr_o = addr_i & ~ADDR_W'(3);
endmodule

// File: rtl/msi_vec_state.sv
module msi_vec_state #(
  parameter int unsigned N       = 32,
  parameter bit          MASK_EN = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] mask_i,
  input  logic [N-1:0] inr_i,
  input  logic [N-1:0] gnt_i,
  output logic [N-1:0] pend_o,
  output logic [N-1:0] due_o
);
  logic         en_q;
  logic [N-1:0] due_q;
  logic [N-1:0] req_ok;
  logic [N-1:0] due_d;

  assign req_ok = req_i & inr_i & {N{en_i}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= en_i;
  end

  if (MASK_EN) begin : g_mask
    logic [N-1:0] pend_q;
    logic [N-1:0] pend_trim;
    logic [N-1:0] promote;
    logic         rise;

    assign rise      = en_i & ~en_q;
    assign pend_trim = rise ? (pend_q & inr_i) : pend_q;
    assign promote   = pend_trim & ~mask_i & inr_i & {N{en_i}};
    assign due_d     = en_i ? ((due_q & ~gnt_i) | promote | (req_ok & ~mask_i)) : '0;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= (pend_trim & ~promote) | (req_ok & mask_i);
    end
    assign pend_o = pend_q;
  end else begin : g_nomask
    logic unused_mask;
    assign unused_mask = ^{mask_i, en_q};
    assign due_d       = en_i ? ((due_q & ~gnt_i) | req_ok) : '0;
    assign pend_o      = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) due_q <= '0;
    else         due_q <= due_d;
  end
  assign due_o = due_q;
endmodule

// File: rtl/msi_engine.sv
module msi_engine
  import msi_pkg::*;
#(
  parameter int unsigned MAX_VEC = 32,
  parameter bit          ADDR64  = 1'b1,
  parameter bit          MASK_EN = 1'b1,
  localparam int unsigned ADDR_W  = ADDR64 ? 64 : 32,
  localparam int unsigned VW      = $clog2(MAX_VEC),
  localparam int unsigned LOG_MAX = VW
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [MAX_VEC-1:0] irq_req_i,
  input  logic               cfg_enable_i,
  input  logic [LOGW-1:0]    cfg_log_vec_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [BASEW-1:0]   cfg_data_i,
  input  logic [MAX_VEC-1:0] cfg_mask_i,
  output logic [MAX_VEC-1:0] pend_o,
  input  logic               intx_req_i,
  output logic               intx_o,
  output logic               msg_valid_o,
  input  logic               msg_ready_i,
  output logic [ADDR_W-1:0]  msg_addr_o,
  output logic [DATAW-1:0]   msg_data_o,
  output logic [VW-1:0]      msg_vec_o
);
  logic [LOGW-1:0]    lg_eff;
  logic [VW:0]        nvec;
  logic [MAX_VEC-1:0] inr;
  logic [MAX_VEC-1:0] due, due_g, gnt_raw, gnt;
  logic [VW-1:0]      pick_idx;
  logic               pick_any, load;
  logic [DATAW-1:0]   fmt_data;
  logic [ADDR_W-1:0]  fmt_addr;

  logic               valid_q;
  logic [VW-1:0]      vec_q;
  logic [DATAW-1:0]   data_q;
  logic [ADDR_W-1:0]  addr_q;

  // clamp the granted count to what the block supports
  assign lg_eff = (cfg_log_vec_i > LOGW'(LOG_MAX)) ? LOGW'(LOG_MAX) : cfg_log_vec_i;
  assign nvec   = (VW+1)'(1) << lg_eff;
  assign inr    = ~({MAX_VEC{1'b1}} << nvec);

  msi_vec_state #(.N(MAX_VEC), .MASK_EN(MASK_EN)) u_state (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cfg_enable_i),
    .req_i  (irq_req_i),
    .mask_i (cfg_mask_i),
    .inr_i  (inr),
    .gnt_i  (gnt),
    .pend_o (pend_o),
    .due_o  (due)
  );

  assign due_g = due & {MAX_VEC{cfg_enable_i}};

  msi_pick #(.N(MAX_VEC)) u_pick (
    .req_i (due_g),
    .gnt_o (gnt_raw),
    .idx_o (pick_idx),
    .any_o (pick_any)
  );

  assign load = ~valid_q | msg_ready_i;
  assign gnt  = load ? gnt_raw : '0;

  msi_msg_fmt #(.N(MAX_VEC), .ADDR_W(ADDR_W)) u_fmt (
    .base_i (cfg_data_i),
    .addr_i (cfg_addr_i),
    .lg_i   (lg_eff),
    .vec_i  (pick_idx),
    .data_o (fmt_data),
    .addr_o (fmt_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      data_q  <= '0;
      addr_q  <= '0;
    end else if (load) begin
      valid_q <= pick_any;
      if (pick_any) begin
        vec_q  <= pick_idx;
        data_q <= fmt_data;
        addr_q <= fmt_addr;
      end
    end
  end

  assign msg_valid_o = valid_q;
  assign msg_vec_o   = vec_q;
  assign msg_data_o  = data_q;
  assign msg_addr_o  = addr_q;
  assign intx_o      = intx_req_i & ~cfg_enable_i;
endmodule

// File: rtl/msi_engine_chk.sv
module msi_engine_chk #(
  parameter int unsigned MAX_VEC = 32,
  parameter bit          ADDR64  = 1'b1,
  parameter bit          MASK_EN = 1'b1,
  localparam int unsigned ADDR_W = ADDR64 ? 64 : 32,
  localparam int unsigned VW     = $clog2(MAX_VEC)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [MAX_VEC-1:0] irq_req_i,
  input logic               cfg_enable_i,
  input logic [MAX_VEC-1:0] cfg_mask_i,
  input logic [MAX_VEC-1:0] pend_o,
  input logic               intx_o,
  input logic               msg_valid_o,
  input logic               msg_ready_i,
  input logic [ADDR_W-1:0]  msg_addr_o,
  input logic [31:0]        msg_data_o,
  input logic [VW-1:0]      msg_vec_o
);
  // R10
  hold_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o && !msg_ready_i |=> msg_valid_o && $stable(msg_data_o)
      && $stable(msg_addr_o) && $stable(msg_vec_o));

  // R7
  intx_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_enable_i |-> !intx_o);

  // R1
  data_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_data_o[31:16] == 16'h0);

  // R2
  addr_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_valid_o |-> msg_addr_o[1:0] == 2'b00);

  // R9
  idle_pend_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cfg_enable_i |=> $stable(pend_o));

  if (MASK_EN) begin : g_mask_chk
    // R3
    masked_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_enable_i && irq_req_i[0] && cfg_mask_i[0] |=> pend_o[0]);
  end
endmodule

bind msi_engine msi_engine_chk #(
  .MAX_VEC (MAX_VEC),
  .ADDR64  (ADDR64),
  .MASK_EN (MASK_EN)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .irq_req_i    (irq_req_i),
  .cfg_enable_i (cfg_enable_i),
  .cfg_mask_i   (cfg_mask_i),
  .pend_o       (pend_o),
  .intx_o       (intx_o),
  .msg_valid_o  (msg_valid_o),
  .msg_ready_i  (msg_ready_i),
  .msg_addr_o   (msg_addr_o),
  .msg_data_o   (msg_data_o),
  .msg_vec_o    (msg_vec_o)
);

// File: tb/msi_engine_bench.sv
module msi_engine_bench;
  localparam time CLK_PERIOD = 10ns;
  localparam int  NV = 8;
  localparam logic [63:0] ADDR = 64'h1234_5678_9ABC_DEF3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [NV-1:0] req = '0;
  logic        en = 1'b0;
  logic [2:0]  lg = 3'd0;
  logic [15:0] dbase = 16'h0;
  logic [NV-1:0] mask = '0;
  logic        ireq = 1'b0;
  logic        ready = 1'b1;

  logic [NV-1:0] pend, pend2;
  logic        intx, intx2, valid, valid2;
  logic [63:0] maddr;
  logic [31:0] maddr2, mdata, mdata2;
  logic [2:0]  mvec, mvec2;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_engine #(.MAX_VEC(NV), .ADDR64(1'b1), .MASK_EN(1'b1)) u_msi_engine (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .cfg_enable_i(en),
    .cfg_log_vec_i(lg), .cfg_addr_i(ADDR), .cfg_data_i(dbase),
    .cfg_mask_i(mask), .pend_o(pend), .intx_req_i(ireq), .intx_o(intx),
    .msg_valid_o(valid), .msg_ready_i(ready), .msg_addr_o(maddr),
    .msg_data_o(mdata), .msg_vec_o(mvec)
  );

  msi_engine #(.MAX_VEC(NV), .ADDR64(1'b0), .MASK_EN(1'b0)) u_msi_engine_nomask (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(req), .cfg_enable_i(en),
    .cfg_log_vec_i(lg), .cfg_addr_i(ADDR[31:0]), .cfg_data_i(dbase),
    .cfg_mask_i(mask), .pend_o(pend2), .intx_req_i(ireq), .intx_o(intx2),
    .msg_valid_o(valid2), .msg_ready_i(1'b1), .msg_addr_o(maddr2),
    .msg_data_o(mdata2), .msg_vec_o(mvec2)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_data(input logic [15:0] d, input int k, input int v);
    int kk = (k > 3) ? 3 : k;
    if (kk == 0) return {16'h0, d};
    return {16'h0, 16'(((32'(d) >> kk) << kk) | v)};
  endfunction

  task automatic pulse(input logic [NV-1:0] m);
    req = m;
    @(negedge clk);
    req = '0;
  endtask

  task automatic expect_msg(input string tag, input int v, input logic [31:0] d);
    bit got = 1'b0;
    for (int i = 0; i < 16 && !got; i++) begin
      @(negedge clk);
      if (valid) got = 1'b1;
    end
    check({tag, " valid"}, 64'(got), 64'd1);
    check({tag, " vec"}, 64'(mvec), 64'(v));
    check({tag, " data"}, 64'(mdata), 64'(d));
    check({tag, " addr"}, maddr, ADDR & ~64'h3);
  endtask

  task automatic expect_none(input string tag, input int cycles);
    bit seen = 1'b0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (valid) seen = 1'b1;
    end
    check({tag, " no message"}, 64'(seen), 64'd0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    ireq = 1'b1;
    repeat (3) @(negedge clk);
    check("reset valid", 64'(valid), 64'd0);
    check("reset pend", 64'(pend), 64'd0);
    check("R7 intx passes while disabled", 64'(intx), 64'd1);
    rst_n = 1'b1;
    @(negedge clk);

    // R7: enabled blocks legacy interrupt
    en = 1'b1;
    @(negedge clk);
    check("R7 intx low while enabled", 64'(intx), 64'd0);
    ireq = 1'b0;

    // R1, R2, R13: sweep all counts, vectors and two data bases
    foreach (dbase_list[bi]) begin
      dbase = dbase_list[bi];
      for (int k = 0; k <= 3; k++) begin
        lg = 3'(k);
        for (int v = 0; v < (1 << k); v++) begin
          pulse(NV'(1) << v);
          check("R13 not yet valid", 64'(valid), 64'd0);
          @(negedge clk);
          check("R13 valid after two edges", 64'(valid), 64'd1);
          check("R1 data merge", 64'(mdata), 64'(exp_data(dbase, k, v)));
          check("R2 address 64", maddr, ADDR & ~64'h3);
          check("R1 vector", 64'(mvec), 64'(v));
        end
      end
    end

    // R12: oversized count clamps to 8 vectors
    dbase = 16'hFFFF;
    lg = 3'd7;
    pulse(8'h20);
    expect_msg("R12 clamp", 5, exp_data(16'hFFFF, 7, 5));

    // R9: out-of-range vector dropped
    lg = 3'd1;
    pulse(8'h20);
    expect_none("R9 out of range", 4);
    check("R9 out of range pend", 64'(pend), 64'd0);

    // R9: disabled requests dropped
    en = 1'b0;
    lg = 3'd3;
    pulse(8'h04);
    @(negedge clk);
    en = 1'b1;
    expect_none("R9 disabled", 4);
    check("R9 disabled pend", 64'(pend), 64'd0);

    // R3, R4: masked request pends, released on unmask
    dbase = 16'hBEEF;
    mask = 8'h24;
    pulse(8'h04);
    check("R3 pend set", 64'(pend), 64'h04);
    expect_none("R3 masked", 3);
    mask = 8'h20;
    expect_msg("R4 unmask", 2, exp_data(16'hBEEF, 3, 2));
    check("R4 pend cleared", 64'(pend), 64'd0);

    // R5, R6: trim and ascending delivery on enable
    mask = 8'hFF;
    pulse(8'h4B);
    check("R3 multi pend", 64'(pend), 64'h4B);
    en = 1'b0;
    lg = 3'd2;
    mask = 8'h01;
    expect_none("R6 held while disabled", 2);
    check("R6 pend held while disabled", 64'(pend), 64'h4B);
    en = 1'b1;
    expect_msg("R6 first", 1, exp_data(16'hBEEF, 2, 1));
    expect_msg("R6 second", 3, exp_data(16'hBEEF, 2, 3));
    check("R5 trimmed pend", 64'(pend), 64'h01);
    expect_none("R5 discarded vector", 3);
    mask = 8'h00;
    expect_msg("R4 release v0", 0, exp_data(16'hBEEF, 2, 0));
    check("R4 pend empty", 64'(pend), 64'd0);

    // R11: simultaneous requests served lowest first
    lg = 3'd3;
    pulse(8'hA6);
    expect_msg("R11 a", 1, exp_data(16'hBEEF, 3, 1));
    expect_msg("R11 b", 2, exp_data(16'hBEEF, 3, 2));
    expect_msg("R11 c", 5, exp_data(16'hBEEF, 3, 5));
    expect_msg("R11 d", 7, exp_data(16'hBEEF, 3, 7));
    expect_none("R11 drained", 3);

    // R10: backpressure holds outputs
    ready = 1'b0;
    pulse(8'h48);
    @(negedge clk);
    check("R10 valid", 64'(valid), 64'd1);
    check("R10 vec", 64'(mvec), 64'd3);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check("R10 held vec", 64'(mvec), 64'd3);
      check("R10 held data", 64'(mdata), 64'(exp_data(16'hBEEF, 3, 3)));
    end
    ready = 1'b1;
    @(negedge clk);
    check("R10 next vec", 64'(mvec), 64'd6);
    check("R10 next valid", 64'(valid), 64'd1);
    expect_none("R10 drained", 3);

    // R8, R2: no-mask variant with 32-bit address
    mask = 8'hFF;
    pulse(8'h04);
    @(negedge clk);
    check("R8 nomask valid", 64'(valid2), 64'd1);
    check("R8 nomask vec", 64'(mvec2), 64'd2);
    check("R8 nomask data", 64'(mdata2), 64'(exp_data(16'hBEEF, 3, 2)));
    check("R2 address 32", 64'(maddr2), 64'(ADDR[31:0] & ~32'h3));
    check("R8 nomask pend", 64'(pend2), 64'd0);
    check("R3 main instance pended", 64'(pend), 64'h04);

    finish_run();
  end

  logic [15:0] dbase_list [2] = '{16'hFFFF, 16'hA5C3};
endmodule